// File: doc/BRIEF.md
# Pipelined Fetch with Late Branch Redirect

This block is the control-flow part of a small five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that handles one kind of control transfer: an unconditional jump relative to the program counter. Each cycle it presents the program counter as a byte address to a combinational instruction-memory read port and captures the 16-bit word that comes back. It then carries the word and its address through four pipeline registers. The high byte of a word is its opcode and the low byte is an unsigned displacement.

A jump collects its own address and displacement as operands in decode. The sum is formed in execute and parked in an ALU-output register. The block steers the next-PC multiplexer to that sum only while the jump sits in the memory stage. Up to that point the fetch side keeps stepping by two bytes, so the three words after a jump are always fetched. Those words are not cancelled: they finish ahead of the jump target. The block has no register file and no data path for other instructions. Every word leaves write-back on a retire stream (valid, address, word), so the order of execution can be observed from outside.

Top module: `lbf_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next cycle shows `imemAddr` = 0 and `retireValid` = 0. The first fetch after reset is from address 0.
- R2: When no jump is in the memory stage, the next fetch address is the current one plus 2, modulo 2^PC_W. With all-zero memory the address steps 252, 254, 0, 2.
- R3: A word is a jump only when bits 15:8 equal 0xC0. Any other opcode, for example 0xC1, leaves the fetch address stepping by 2.
- R4: The jump target is the jump's own address plus bits 7:0 taken as an unsigned number, modulo 2^PC_W. A jump at 252 with displacement 10 lands at 6, and a jump at 0 with displacement 0xFA lands at 250.
- R5: A jump fetched in cycle t causes the fetch of its target in cycle t+4. Cycles t+1 to t+3 fetch the jump's address plus 2, plus 4 and plus 6.
- R6: The three words fetched after a jump are not cancelled. They retire in fetch order, before the target, and after reset the retire stream has no gaps.
- R7: A word fetched in cycle t appears in cycle t+4 with `retireValid` = 1, `retirePc` equal to its fetch address and `retireInstr` equal to the fetched word. Before that, `retireValid` is 0 after reset.
- R8: A jump that is one of the three words behind an earlier jump still redirects, in its own cycle t+4. Back-to-back jumps at 20 (displacement 0x10) and 22 (displacement 0x20) retire the sequence 20, 22, 24, 26, 36, 54, 56.
- R9: An all-zero word passes through like any other word and retires with its own address and the value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | PC_W | Byte address of the word being fetched (the PC) |
| imemData | input | 16 | Word read combinationally at `imemAddr`, opcode in bits 15:8 |
| retireValid | output | 1 | A word is leaving write-back this cycle |
| retirePc | output | PC_W | Fetch address of the retiring word |
| retireInstr | output | 16 | The retiring word |

## Verification
The fetch address must follow the jump by exactly four cycles, and retire must trail fetch by exactly four cycles. The bench therefore keeps a behavioural history of fetched words. Just before each rising edge it predicts the address now on `imemAddr`. It takes the retire value from the fetch four entries back, and it picks the next address from the entry three back when that entry is a jump. The bench samples the outputs on the falling edge. It tracks reset through the value of `rst` seen at the last rising edge, so the reset cycle and the first fetch cycle stay aligned. The retired addresses of each program are also compared with hand-worked lists, which cover the cancelled-nothing shadow, back-to-back jumps, wrap-around and the non-jump 0xC1 opcode.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 8;
  localparam int OFS_W   = INSTR_W - OPC_W;
  localparam logic [OPC_W-1:0] OPC_JUMP = 8'hC0;

  // registered stages behind fetch
  localparam int N_STAGE = 4;
  localparam int ST_ID   = 0;
  localparam int ST_EX   = 1;
  localparam int ST_MEM  = 2;
  localparam int ST_WB   = 3;

  typedef struct packed {
    logic loadTarget;  // jump in EX: capture adder result
    logic takeTarget;  // jump in MEM: steer next-PC mux
  } strobes_t;
endpackage

// File: rtl/lbf_ctrl.sv
module lbf_ctrl
  import lbf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] idOpcode,
  output strobes_t         strobes,
  output logic             retireValid
);
  logic [N_STAGE-1:0] validQ;
  logic jumpExQ;
  logic jumpMemQ;
  logic idJump;

  assign idJump = validQ[ST_ID] && (idOpcode == OPC_JUMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ   <= '0;
      jumpExQ  <= 1'b0;
      jumpMemQ <= 1'b0;
    end else begin
      validQ   <= {validQ[N_STAGE-2:0], 1'b1};
      jumpExQ  <= idJump;
      jumpMemQ <= jumpExQ;
    end
  end

  assign strobes.loadTarget = jumpExQ;
  assign strobes.takeTarget = jumpMemQ;
  assign retireValid        = validQ[ST_WB];
endmodule

// File: rtl/lbf_datapath.sv
module lbf_datapath
  import lbf_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int PC_STEP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic [INSTR_W-1:0] imemData,
  output logic [PC_W-1:0]    imemAddr,
  output logic [OPC_W-1:0]   idOpcode,
  output logic [PC_W-1:0]    memTarget,
  output logic [PC_W-1:0]    retirePc,
  output logic [INSTR_W-1:0] retireInstr
);
  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] pcNext;
  logic [N_STAGE-1:0][PC_W-1:0]    stPc;
  logic [N_STAGE-1:0][INSTR_W-1:0] stIr;
  logic [PC_W-1:0] opBaseQ;
  logic [PC_W-1:0] opOfsQ;
  logic [PC_W-1:0] aluOutQ;
  logic [PC_W-1:0] targetSum;

  // next-PC mux: registered target while a jump is in MEM
  assign pcNext = strobes.takeTarget ? aluOutQ : pcQ + PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  // instruction and address travel together through every stage
  always_ff @(posedge clk) begin
    if (rst) begin
      stPc <= '0;
      stIr <= '0;
    end else begin
      stPc[ST_ID] <= pcQ;
      stIr[ST_ID] <= imemData;
      for (int s = 1; s < N_STAGE; s++) begin
        stPc[s] <= stPc[s-1];
        stIr[s] <= stIr[s-1];
      end
    end
  end

  // decode-stage operand capture: own PC and zero-extended displacement
  always_ff @(posedge clk) begin
    if (rst) begin
      opBaseQ <= '0;
      opOfsQ  <= '0;
    end else begin
      opBaseQ <= stPc[ST_ID];
      opOfsQ  <= PC_W'(stIr[ST_ID][OFS_W-1:0]);
    end
  end

  assign targetSum = opBaseQ + opOfsQ;

  // ALU-output register, written only for a jump in EX
  always_ff @(posedge clk) begin
    if (rst)                     aluOutQ <= '0;
    else if (strobes.loadTarget) aluOutQ <= targetSum;
  end

  assign imemAddr    = pcQ;
  assign idOpcode    = stIr[ST_ID][INSTR_W-1:OFS_W];
  assign memTarget   = aluOutQ;
  assign retirePc    = stPc[ST_WB];
  assign retireInstr = stIr[ST_WB];
endmodule

// File: rtl/lbf_top.sv
module lbf_top
  import lbf_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic               retireValid,
  output logic [PC_W-1:0]    retirePc,
  output logic [INSTR_W-1:0] retireInstr
);
  strobes_t        strobes;
  logic [OPC_W-1:0] idOpcode;
  logic [PC_W-1:0]  memTarget;

  lbf_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .idOpcode    (idOpcode),
    .strobes     (strobes),
    .retireValid (retireValid)
  );

  lbf_datapath #(.PC_W(PC_W), .PC_STEP(2)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .imemData    (imemData),
    .imemAddr    (imemAddr),
    .idOpcode    (idOpcode),
    .memTarget   (memTarget),
    .retirePc    (retirePc),
    .retireInstr (retireInstr)
  );
endmodule

// File: rtl/lbf_checker.sv
module lbf_checker
  import lbf_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    imemAddr,
  input logic [INSTR_W-1:0] imemData,
  input logic               retireValid,
  input logic [PC_W-1:0]    retirePc,
  input logic [INSTR_W-1:0] retireInstr,
  input logic               takeTarget,
  input logic [PC_W-1:0]    memTarget
);
  // set once a full non-reset cycle has passed
  logic liveQ;
  always_ff @(posedge clk) begin
    if (rst) liveQ <= 1'b0;
    else     liveQ <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!retireValid && imemAddr == '0));

  assert_step_two_R2: assert property (@(posedge clk) disable iff (rst)
    (liveQ && !takeTarget) |=> imemAddr == PC_W'($past(imemAddr) + PC_W'(2)));

  assert_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    (liveQ && takeTarget) |=> imemAddr == $past(memTarget));

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (liveQ && retireValid) |=> retireValid);

  assert_retire_pc_R7: assert property (@(posedge clk) disable iff (rst)
    retireValid |-> retirePc == $past(imemAddr, 4));

  assert_retire_word_R7: assert property (@(posedge clk) disable iff (rst)
    retireValid |-> retireInstr == $past(imemData, 4));
endmodule

bind lbf_top lbf_checker #(.PC_W(PC_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .imemAddr    (imemAddr),
  .imemData    (imemData),
  .retireValid (retireValid),
  .retirePc    (retirePc),
  .retireInstr (retireInstr),
  .takeTarget  (strobes.takeTarget),
  .memTarget   (memTarget)
);

// File: tb/lbf_top_tb_top.sv
module lbf_top_tb_top;
  localparam int PC_W  = 8;
  localparam int MEMSZ = 1 << PC_W;

  typedef struct {
    int          pc;
    logic [15:0] ins;
  } fetch_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rstQ = 1'b1;
  logic [PC_W-1:0] imemAddr;
  logic [15:0]     imemData;
  logic            retireValid;
  logic [PC_W-1:0] retirePc;
  logic [15:0]     retireInstr;

  logic [7:0] mem [MEMSZ];
  fetch_t hist[$];
  int retPcs[$];
  int retIns[$];
  fetch_t e;
  fetch_t f;
  int mPc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign imemData = {mem[imemAddr], mem[PC_W'(imemAddr + PC_W'(1))]};

  lbf_top #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .retireValid(retireValid), .retirePc(retirePc), .retireInstr(retireInstr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) rstQ <= rst;

  // behavioural reference, evaluated mid-cycle
  always @(negedge clk) begin
    if (rstQ) begin
      check(imemAddr == 0, "R1 fetch address in reset", int'(imemAddr), 0);
      check(!retireValid, "R1 retire valid in reset", int'(retireValid), 0);
      hist.delete();
      mPc = 0;
    end else begin
      check(int'(imemAddr) == mPc, "R5 fetch address", int'(imemAddr), mPc);
      if (hist.size() >= 4) begin
        e = hist[hist.size()-4];
        check(retireValid, "R7 retire valid", int'(retireValid), 1);
        check(int'(retirePc) == e.pc, "R7 retire pc", int'(retirePc), e.pc);
        check(retireInstr == e.ins, "R7 retire word", int'(retireInstr), int'(e.ins));
        if (retireValid) begin
          retPcs.push_back(int'(retirePc));
          retIns.push_back(int'(retireInstr));
        end
      end else begin
        check(!retireValid, "R7 retire valid before fill", int'(retireValid), 0);
      end
    end
    if (rst) begin
      hist.delete();
      mPc = 0;
    end else begin
      f.pc  = mPc;
      f.ins = {mem[mPc], mem[(mPc + 1) % MEMSZ]};
      hist.push_back(f);
      e = hist[(hist.size() >= 4) ? hist.size()-4 : 0];
      if (hist.size() >= 4 && e.ins[15:8] == 8'hC0)
        mPc = (e.pc + int'(e.ins[7:0])) % MEMSZ;
      else
        mPc = (mPc + 2) % MEMSZ;
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
  endtask

  task automatic putWord(input int addr, input logic [7:0] opc, input logic [7:0] ofs);
    mem[addr]     = opc;
    mem[addr + 1] = ofs;
  endtask

  task automatic startRun();
    @(posedge clk);
    rst <= 1'b1;
    repeat (3) @(posedge clk);
    retPcs.delete();
    retIns.delete();
    rst <= 1'b0;
  endtask

  task automatic compareList(input int exp[], input string tag);
    for (int i = 0; i < exp.size(); i++) begin
      if (i < retPcs.size())
        check(retPcs[i] == exp[i], tag, retPcs[i], exp[i]);
      else
        check(1'b0, tag, -1, exp[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finishRun();
  end

  initial begin
    clearMem();
    repeat (2) @(posedge clk);

    // Program A: single jump 12 -> 56, nops in the shadow
    @(posedge clk); rst <= 1'b1;
    clearMem();
    for (int i = 0; i < 6; i++) putWord(2 * i, 8'h0A + 8'(i), 8'h01);
    putWord(12, 8'hC0, 8'h2C);
    putWord(14, 8'h10, 8'h0A);
    putWord(56, 8'h00, 8'h01);
    startRun();
    repeat (40) @(posedge clk);
    compareList('{0, 2, 4, 6, 8, 10, 12, 14, 16, 18, 56, 58}, "R6 shadow retire order");
    check(retPcs.size() > 9 && retPcs[8] == 16 && retIns[8] == 0, "R9 zero word retires",
          (retIns.size() > 8) ? retIns[8] : -1, 0);

    // Program B: back-to-back jumps, plus a reset in the middle of the run
    @(posedge clk); rst <= 1'b1;
    clearMem();
    putWord(20, 8'hC0, 8'h10);
    putWord(22, 8'hC0, 8'h20);
    startRun();
    repeat (12) @(posedge clk);
    startRun();
    repeat (40) @(posedge clk);
    compareList('{0, 2, 4, 6, 8, 10, 12, 14, 16, 18, 20, 22, 24, 26, 36, 54, 56},
                "R8 jump in shadow");

    // Program C: wrap-around targets, unsigned offsets, near-miss opcode
    @(posedge clk); rst <= 1'b1;
    clearMem();
    putWord(0, 8'hC0, 8'hFA);
    putWord(2, 8'hC1, 8'h05);
    putWord(252, 8'hC0, 8'h0A);
    startRun();
    repeat (40) @(posedge clk);
    compareList('{0, 2, 4, 6, 250, 252, 254, 0, 2, 6, 8, 250}, "R4 wrapped target");
    check(retPcs.size() > 2 && retPcs[2] == 4, "R3 opcode 0xC1 not a jump",
          (retPcs.size() > 2) ? retPcs[2] : -1, 4);

    // Program D: all zeros, sequential wrap of the PC
    @(posedge clk); rst <= 1'b1;
    clearMem();
    startRun();
    repeat (140) @(posedge clk);
    check(retPcs.size() > 128 && retPcs[127] == 254, "R2 step before wrap",
          (retPcs.size() > 127) ? retPcs[127] : -1, 254);
    check(retPcs.size() > 128 && retPcs[128] == 0, "R2 step wraps to zero",
          (retPcs.size() > 128) ? retPcs[128] : -1, 0);

    @(posedge clk); rst <= 1'b1;
    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule